// File: doc/BRIEF.md
# Control Register Packet Decoder

This block sits behind a byte-wide host link and turns the incoming byte stream into 32-bit setup packets. Each packet names an operation (write or read), a register address and a 16-bit value. A write updates one entry of a small on-chip register file. A read sends the current 16-bit contents of one entry back to the host as two bytes on a separate response stream.

No register is touched until all four bytes of a packet are in and the packet has passed its validity check. A packet with an unknown operation code or an address outside the implemented window is dropped. It changes nothing, produces no response and raises a single-cycle error pulse. Every accepted write also shows up on a one-cycle strobe with its address and data, so that neighbouring logic can follow configuration changes as they happen. The whole register file is exported as a flat vector.

Top module: `ctrl_pkt_decoder`

## Requirements
- R1: Bytes are taken on `in_valid && in_ready`, most significant first. The 32-bit packet is {byte3, byte2, byte1, byte0}. Bits 31:28 hold the operation code, bits 27:16 the 12-bit address and bits 15:0 the data.
- R2: Operation code 0x1 with an address below NREG (0x000 to 0x00F by default) is a write. In the cycle after the last byte is taken, `wr_stb` is high for exactly one cycle, and `wr_addr` and `wr_data` carry the packet's address and data in that same cycle. The register, seen at `cfg_regs[addr*16 +: 16]`, shows the new value from the following cycle on.
- R3: A packet of fewer than four bytes never changes `cfg_regs` or raises `wr_stb`, however long the link stays idle between its bytes.
- R4: Operation code 0x2 with an address below NREG is a read. It returns two bytes on `rsp_data`, handed over on `rsp_valid && rsp_ready`: bits 15:8 of the register first, then bits 7:0.
- R5: From the cycle after the last byte of a valid read until both response bytes have been taken, `in_ready` is low. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds its value.
- R6: Any operation code other than 0x1 or 0x2 raises `err_pulse` for exactly one cycle, in the cycle after the last byte. It leaves `cfg_regs` unchanged, raises no `wr_stb` and produces no response.
- R7: A write or read whose address is NREG or above is handled exactly like R6: a one-cycle `err_pulse`, no register change and no response.
- R8: A synchronous active-low reset clears every register to zero, drops any partly received packet and any pending response, and makes the next byte taken count as byte 3.
- R9: In the cycle after the last byte of any packet, `in_ready` is low for the decode cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host byte present |
| in_data | input | 8 | Host byte, most significant byte of the packet first |
| in_ready | output | 1 | Decoder can take a byte |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response byte, high byte first |
| rsp_ready | input | 1 | Host takes the response byte |
| wr_stb | output | 1 | One-cycle pulse for an accepted write |
| wr_addr | output | 12 | Address of the accepted write |
| wr_data | output | 16 | Data of the accepted write |
| err_pulse | output | 1 | One-cycle pulse for a discarded packet |
| cfg_regs | output | NREG*16 | Register file, entry i at bits i*16+15 : i*16 |

## Verification
The hardest condition to reach from the ports is a read response stalled by the host while more traffic is already waiting. The bench holds `rsp_ready` low across a whole read and queues the next packet behind it, so it can check that the input side stays closed and that the high byte does not move. A pseudo-random backpressure pattern then mixes writes and reads, and a scoreboard queue matches every response byte against a model of the register file. Partial packets are also covered: a packet is stalled before its last byte, and a reset is applied in the middle of another, to check that no register moves early and that byte counting starts over.

// File: rtl/cfgdec_pkg.sv
`timescale 1ns/1ps
// Package: cfgdec_pkg
// Shared widths, operation codes and the packet layout of the control
// register packet decoder. The field positions are fixed by the link format.
package cfgdec_pkg;

    localparam int BYTE_W    = 8;
    localparam int PKT_BYTES = 4;
    localparam int PKT_W     = BYTE_W * PKT_BYTES;
    localparam int CMD_W     = 4;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 16;
    localparam int RSP_BYTES = DATA_W / BYTE_W;

    // Operation codes carried in the top nibble of the packet
    localparam logic [CMD_W-1:0] OP_WRITE = 4'h1;
    localparam logic [CMD_W-1:0] OP_READ  = 4'h2;

    // Packet layout, most significant field first
    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } setup_pkt_t;

    // States of the response byte sequencer
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIGH = 2'd1,
        RSP_LOW  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/cfgdec_assembler.sv
`timescale 1ns/1ps
// Module: cfgdec_assembler
// Gathers bytes from a valid/ready link into a 32-bit packet, most
// significant byte first. When the last byte is taken, the full packet is
// presented for exactly one cycle (pkt_vld). Input is refused during that
// decode cycle and whenever the parent asserts hold.
// Assumes: hold comes from registered state only, so in_ready is stable
// between clock edges.
module cfgdec_assembler
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              hold,
    output logic              in_ready,
    output logic              pkt_vld,
    output setup_pkt_t        pkt
);

    localparam int CNT_W   = $clog2(PKT_BYTES);
    localparam int SHIFT_W = PKT_W - BYTE_W;

    logic [CNT_W-1:0]   slot_q;    // position of the next byte, counting down
    logic [SHIFT_W-1:0] shift_q;   // bytes gathered so far
    logic               pkt_vld_q;
    setup_pkt_t         pkt_q;
    logic               take;
    logic               last_slot;

    // Accept a byte when not in a decode cycle and not held off
    assign in_ready  = !hold && !pkt_vld_q;
    assign take      = in_valid && in_ready;
    assign last_slot = (slot_q == '0);

    // Track the byte position and gather bytes into a packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= CNT_W'(PKT_BYTES - 1);
            shift_q   <= '0;
            pkt_vld_q <= 1'b0;
            pkt_q     <= '0;
        end else begin
            pkt_vld_q <= take && last_slot;
            if (take) begin
                if (last_slot) begin
                    pkt_q  <= setup_pkt_t'({shift_q, in_data});
                    slot_q <= CNT_W'(PKT_BYTES - 1);
                end else begin
                    shift_q <= {shift_q[SHIFT_W-BYTE_W-1:0], in_data};
                    slot_q  <= slot_q - 1'b1;
                end
            end
        end
    end

    assign pkt_vld = pkt_vld_q;
    assign pkt     = pkt_q;

endmodule

// File: rtl/cfgdec_validator.sv
`timescale 1ns/1ps
// Module: cfgdec_validator
// Combinational check of a complete packet: classifies it as an accepted
// write, an accepted read or a discarded packet, and yields the register
// index for accepted ones.
// Assumes: pkt is stable for the single cycle in which pkt_vld is high.
module cfgdec_validator
    import cfgdec_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic             pkt_vld,
    input  setup_pkt_t       pkt,
    output logic             wr_en,
    output logic             rd_en,
    output logic             bad,
    output logic [IDX_W-1:0] idx
);

    logic op_is_wr;
    logic op_is_rd;
    logic addr_ok;

    // Decode the operation code and check the address window
    always_comb begin
        op_is_wr = (pkt.op == OP_WRITE);
        op_is_rd = (pkt.op == OP_READ);
        addr_ok  = (pkt.addr < ADDR_W'(NREG));
    end

    // Classify the packet only in its decode cycle
    always_comb begin
        wr_en = pkt_vld && op_is_wr && addr_ok;
        rd_en = pkt_vld && op_is_rd && addr_ok;
        bad   = pkt_vld && !((op_is_wr || op_is_rd) && addr_ok);
        idx   = pkt.addr[IDX_W-1:0];
    end

endmodule

// File: rtl/cfgdec_regfile.sv
`timescale 1ns/1ps
// Module: cfgdec_regfile
// NREG registers of DATA_W bits with one write port and one
// combinational read port. The whole file is also exported flat.
// Assumes: wr_idx and rd_idx are below NREG whenever they are used.
module cfgdec_regfile
    import cfgdec_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [DATA_W-1:0]      rd_data,
    output logic [NREG*DATA_W-1:0] flat
);

    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        // Hold one entry; load it when the write port selects it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs_q[g] <= wr_data;
            end
        end
        assign flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    // Read the selected entry
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/cfgdec_responder.sv
`timescale 1ns/1ps
// Module: cfgdec_responder
// Captures a 16-bit read result and sends it as two bytes, high byte
// first, on a valid/ready stream. busy stays high until the low byte is
// taken.
// Assumes: load is only asserted while busy is low.
module cfgdec_responder
    import cfgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);

    rsp_state_e        state_q;
    logic [DATA_W-1:0] word_q;

    // Step through high byte and low byte as each one is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                RSP_IDLE: begin
                    if (load) begin
                        word_q  <= load_data;
                        state_q <= RSP_HIGH;
                    end
                end
                RSP_HIGH: begin
                    if (out_ready) begin
                        state_q <= RSP_LOW;
                    end
                end
                RSP_LOW: begin
                    if (out_ready) begin
                        state_q <= RSP_IDLE;
                    end
                end
                default: state_q <= RSP_IDLE;
            endcase
        end
    end

    // Present the byte for the current state
    always_comb begin
        busy      = (state_q != RSP_IDLE);
        out_valid = busy;
        out_data  = (state_q == RSP_LOW) ? word_q[BYTE_W-1:0]
                                         : word_q[DATA_W-1:BYTE_W];
    end

endmodule

// File: rtl/ctrl_pkt_decoder.sv
`timescale 1ns/1ps
// Module: ctrl_pkt_decoder
// Control register packet decoder. Assembles 4-byte setup packets from a
// byte link, validates them, applies accepted writes to an NREG-entry
// register file and answers accepted reads with two response bytes.
// Discarded packets give a one-cycle error pulse and change nothing.
// Assumes: synchronous active-low reset; the host follows valid/ready.
module ctrl_pkt_decoder
    import cfgdec_pkg::*;
#(
    parameter int NREG = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   rsp_valid,
    output logic [7:0]             rsp_data,
    input  logic                   rsp_ready,
    output logic                   wr_stb,
    output logic [11:0]            wr_addr,
    output logic [15:0]            wr_data,
    output logic                   err_pulse,
    output logic [NREG*16-1:0]     cfg_regs
);

    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic              pkt_vld;
    setup_pkt_t        pkt;
    logic              wr_en;
    logic              rd_en;
    logic              bad;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_word;
    logic              rsp_busy;

    cfgdec_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .hold     (rsp_busy),
        .in_ready (in_ready),
        .pkt_vld  (pkt_vld),
        .pkt      (pkt)
    );

    cfgdec_validator #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_val (
        .pkt_vld (pkt_vld),
        .pkt     (pkt),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .bad     (bad),
        .idx     (idx)
    );

    cfgdec_regfile #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (pkt.data),
        .rd_idx  (idx),
        .rd_data (rd_word),
        .flat    (cfg_regs)
    );

    cfgdec_responder u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rd_en),
        .load_data (rd_word),
        .busy      (rsp_busy),
        .out_valid (rsp_valid),
        .out_data  (rsp_data),
        .out_ready (rsp_ready)
    );

    // Report accepted writes and discarded packets in the decode cycle
    always_comb begin
        wr_stb    = wr_en;
        wr_addr   = pkt.addr;
        wr_data   = pkt.data;
        err_pulse = bad;
    end

endmodule

// File: rtl/ctrl_pkt_decoder_chk.sv
`timescale 1ns/1ps
// Module: ctrl_pkt_decoder_chk
// Property checker for ctrl_pkt_decoder, attached through bind. Watches the
// top-level ports only.
// Assumes: reset is asserted at time zero.
module ctrl_pkt_decoder_chk #(
    parameter int NREG = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_ready,
    input logic               rsp_valid,
    input logic [7:0]         rsp_data,
    input logic               rsp_ready,
    input logic               wr_stb,
    input logic [11:0]        wr_addr,
    input logic [15:0]        wr_data,
    input logic               err_pulse,
    input logic [NREG*16-1:0] cfg_regs
);

    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic armed_q;

    // Arm the history-based checks one cycle after reset is released
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_WR_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);                                            // R2
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (cfg_regs[int'($past(wr_addr[IDX_W-1:0]))*16 +: 16] == $past(wr_data))); // R2
    AST_REGS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !wr_stb) |=> $stable(cfg_regs));                    // R3
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R5
    AST_INPUT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !in_ready);                                       // R5
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);                                      // R6
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !wr_stb);                                         // R6
    AST_ERR_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && !rsp_valid) |=> !rsp_valid);                      // R7
    AST_DECODE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || err_pulse) |-> !in_ready);                           // R9

endmodule

bind ctrl_pkt_decoder ctrl_pkt_decoder_chk #(.NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_ready (rsp_ready),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .err_pulse (err_pulse),
    .cfg_regs  (cfg_regs)
);

// File: tb/ctrl_pkt_decoder_bench.sv
`timescale 1ns/1ps
// Bench: scoreboard for ctrl_pkt_decoder. Driver tasks push expected
// response bytes into a queue; a monitor pops and compares them.
module ctrl_pkt_decoder_bench;

    localparam int NREG = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [7:0]         in_data = '0;
    logic               in_ready;
    logic               rsp_valid;
    logic [7:0]         rsp_data;
    logic               rsp_ready = 1'b1;
    logic               wr_stb;
    logic [11:0]        wr_addr;
    logic [15:0]        wr_data;
    logic               err_pulse;
    logic [NREG*16-1:0] cfg_regs;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          bp_mode = 0;
    logic [7:0]  lfsr = 8'hA7;
    logic [15:0] mdl [NREG];
    logic [7:0]  exp_q [$];
    logic [7:0]  exp_b;

    ctrl_pkt_decoder #(.NREG(NREG)) u_ctrl_pkt_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_ready(rsp_ready), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .err_pulse(err_pulse), .cfg_regs(cfg_regs)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NREG*16-1:0] mdl_flat();
        logic [NREG*16-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*16 +: 16] = mdl[i];
        return f;
    endfunction

    // Response ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (bp_mode)
            0:       rsp_ready = 1'b1;
            1:       rsp_ready = 1'b0;
            default: rsp_ready = lfsr[0];
        endcase
    end

    // Monitor: compare every handed-over response byte with the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected response byte", {24'h0, rsp_data}, 32'h0);
            end else begin
                exp_b = exp_q.pop_front();
                chk(rsp_data == exp_b, "R4 response byte", {24'h0, rsp_data}, {24'h0, exp_b});
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [3:0] op, input logic [11:0] a, input logic [15:0] d);
        send_byte({op, a[11:8]});
        send_byte(a[7:0]);
        send_byte(d[15:8]);
        send_byte(d[7:0]);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [15:0] d);
        send_pkt(4'h1, a, d);
        @(negedge clk);
        chk(wr_stb == 1'b1, "R2 write strobe", {31'h0, wr_stb}, 32'h1);
        chk(wr_addr == a, "R1 strobe address", {20'h0, wr_addr}, {20'h0, a});
        chk(wr_data == d, "R1 strobe data", {16'h0, wr_data}, {16'h0, d});
        chk(in_ready == 1'b0, "R9 decode cycle closed", {31'h0, in_ready}, 32'h0);
        mdl[a[3:0]] = d;
        @(negedge clk);
        chk(wr_stb == 1'b0, "R2 strobe one cycle", {31'h0, wr_stb}, 32'h0);
        chk(cfg_regs == mdl_flat(), "R2 register updated",
            {16'h0, cfg_regs[a[3:0]*16 +: 16]}, {16'h0, d});
    endtask

    task automatic do_bad(input logic [3:0] op, input logic [11:0] a, input logic [15:0] d, input string req);
        send_pkt(op, a, d);
        @(negedge clk);
        chk(err_pulse == 1'b1, {req, " error pulse"}, {31'h0, err_pulse}, 32'h1);
        chk(wr_stb == 1'b0, {req, " no strobe"}, {31'h0, wr_stb}, 32'h0);
        @(negedge clk);
        chk(err_pulse == 1'b0, {req, " pulse one cycle"}, {31'h0, err_pulse}, 32'h0);
        chk(cfg_regs == mdl_flat(), {req, " registers unchanged"}, cfg_regs[31:0], mdl_flat() >> 0);
        chk(rsp_valid == 1'b0, {req, " no response"}, {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic do_read(input logic [11:0] a);
        exp_q.push_back(mdl[a[3:0]][15:8]);
        exp_q.push_back(mdl[a[3:0]][7:0]);
        send_pkt(4'h2, a, 16'h0);
    endtask

    task automatic drain();
        for (int t = 0; t < 200 && exp_q.size() != 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4 all response bytes seen", exp_q.size(), 32'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        exp_q.delete();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Stimulus
    initial begin
        do_reset();
        @(negedge clk);
        chk(cfg_regs == '0, "R8 registers clear after reset", cfg_regs[31:0], 32'h0);
        chk(in_ready == 1'b1, "R8 ready after reset", {31'h0, in_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R8 no response after reset", {31'h0, rsp_valid}, 32'h0);

        // Writes, including the top of the window and a byte-order pattern (R1, R2)
        do_write(12'h000, 16'hA5C3);
        do_write(12'h00F, 16'h1234);
        do_write(12'h007, 16'hFFFF);
        do_write(12'h003, 16'h8001);

        // Discarded packets: bad operation codes (R6) and addresses (R7)
        do_bad(4'h0, 12'h002, 16'h5555, "R6 op 0x0");
        do_bad(4'h3, 12'h002, 16'h5555, "R6 op 0x3");
        do_bad(4'hF, 12'h00F, 16'h0000, "R6 op 0xF");
        do_bad(4'h1, 12'h010, 16'h7777, "R7 write addr 0x010");
        do_bad(4'h1, 12'hFFF, 16'h7777, "R7 write addr 0xFFF");
        do_bad(4'h2, 12'h100, 16'h0000, "R7 read addr 0x100");

        // Reads with the host always ready (R4)
        do_read(12'h000);
        do_read(12'h00F);
        do_read(12'h003);
        drain();

        // Stalled response and a packet queued behind it (R5)
        bp_mode = 1;
        @(negedge clk);
        do_read(12'h00F);
        @(negedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b1, "R5 response pending", {31'h0, rsp_valid}, 32'h1);
        chk(rsp_data == 8'h12, "R5 high byte first", {24'h0, rsp_data}, 32'h12);
        chk(in_ready == 1'b0, "R5 input closed", {31'h0, in_ready}, 32'h0);
        fork
            do_write(12'h009, 16'h4242);
            begin
                repeat (6) @(negedge clk);
                chk(rsp_data == 8'h12, "R5 byte held under stall", {24'h0, rsp_data}, 32'h12);
                chk(in_ready == 1'b0, "R5 input still closed", {31'h0, in_ready}, 32'h0);
                chk(cfg_regs[9*16 +: 16] == 16'h0, "R5 queued write not applied", {16'h0, cfg_regs[9*16 +: 16]}, 32'h0);
                bp_mode = 0;
            end
        join
        drain();

        // Mixed traffic under pseudo-random backpressure (R2, R4)
        bp_mode = 2;
        for (int i = 0; i < 20; i++) begin
            do_write(12'(i % NREG), 16'(i * 16'h1357) ^ 16'hC0DE);
            do_read(12'((i * 5) % NREG));
        end
        drain();
        bp_mode = 0;

        // Partial packet stalled before its last byte (R3)
        send_byte(8'h10);
        send_byte(8'h04);
        send_byte(8'hBE);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(cfg_regs == mdl_flat() && !wr_stb, "R3 partial packet changes nothing",
                {16'h0, cfg_regs[4*16 +: 16]}, {16'h0, mdl[4]});
        end
        send_byte(8'hEF);
        @(negedge clk);
        chk(wr_stb == 1'b1 && wr_data == 16'hBEEF, "R3 packet completes", {16'h0, wr_data}, 32'hBEEF);
        mdl[4] = 16'hBEEF;
        @(negedge clk);
        chk(cfg_regs == mdl_flat(), "R3 register after completion", {16'h0, cfg_regs[4*16 +: 16]}, 32'hBEEF);

        // Reset in the middle of a packet (R8)
        send_byte(8'h10);
        send_byte(8'h05);
        do_reset();
        @(negedge clk);
        chk(cfg_regs == '0, "R8 registers cleared", cfg_regs[31:0], 32'h0);
        do_write(12'h005, 16'h0F0F);
        do_read(12'h005);
        do_read(12'h000);
        drain();

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule